// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a synthesizable synchronous static RAM whose data bus can go straight from a read to a write and back with no idle cycle. Address, control and write data are all taken on the rising clock edge. Write data arrives late: a fixed number of clocks after its write command, and the number depends on the output mode. A read that meets a write still in flight gets the in-flight bytes.

A static mode input selects one of two output modes. In pipelined mode, read data passes through an output register. In flow-through mode, data comes straight from the array. A two-bit burst counter, preset from the two low address bits and stepped by an advance input, produces the addresses of up to four beats. It runs in linear or interleaved order. Words are made of 9-bit bytes, and each byte has its own write enable. Three chip enables allow depth expansion, a clock enable freezes the whole core, an asynchronous output enable gates the data-valid output, and a sleep input refuses accesses.

Top module: `zt_sram`

## Requirements
- R1: A new access starts only on an enabled edge with `advance` low, `sel1N` and `sel2N` low, `sel3` high and `sleep` low. Any other enabled edge without `advance` is a deselect: nothing is stored, and no read data is flagged on `dOutEn`. `dOutEn` is low while reset is held.
- R2: In pipelined mode (`pipeMode`=1), a read taken at clock edge k places its word on `dOut`, with `dOutEn` high, from edge k+1 onward.
- R3: In flow-through mode (`pipeMode`=0), a read taken at edge k places its word on `dOut`, with `dOutEn` high, right after edge k.
- R4: In pipelined mode, the data of a write taken at edge k is sampled from `dIn` at edge k+2.
- R5: In flow-through mode, the data of a write taken at edge k is sampled from `dIn` at edge k+1.
- R6: Reads and writes may alternate on consecutive edges in any mix, and every read returns the most recent data written to its address.
- R7: With `orderSel`=0, burst beat n (n counted from 0 at the start edge) uses low address bits (start + n) mod 4. The upper bits stay those of the start address.
- R8: With `orderSel`=1, burst beat n uses low address bits start XOR (n mod 4).
- R9: Byte b occupies `dIn`/`dOut` bits [9b+8:9b]. Each beat samples `byteWeN` on its own edge, and a low `byteWeN[b]` stores that byte. Bytes whose enable is high keep their old value.
- R10: An edge with `ceN` high changes nothing. The burst counter, pending writes, output register and array all hold, and `dOut` stays unchanged.
- R11: In pipelined mode, a read of an address whose write data is arriving on the same edge returns the new bytes merged over the old word.
- R12: `oeN` high forces `dOutEn` low at once, without waiting for a clock edge.
- R13: An enabled edge with `sleep` high starts no access, and it ends any burst in progress, so a following `advance` does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pipeMode | input | 1 | 1 = pipelined output, 0 = flow-through (static) |
| orderSel | input | 1 | Burst order: 0 = linear, 1 = interleaved |
| ceN | input | 1 | Clock enable, active low |
| sel1N | input | 1 | Chip enable, active low |
| sel2N | input | 1 | Chip enable, active low |
| sel3 | input | 1 | Chip enable, active high |
| sleep | input | 1 | Blocks accesses, active high |
| advance | input | 1 | Step the burst counter instead of loading an address |
| weN | input | 1 | Write command, active low (high = read) |
| byteWeN | input | NBYTES | Per-byte write enables, active low |
| addr | input | ADDR_W | Word address |
| dIn | input | NBYTES*BYTE_W | Late write data |
| oeN | input | 1 | Asynchronous output enable, active low |
| dOut | output | NBYTES*BYTE_W | Read data |
| dOutEn | output | 1 | High while `dOut` carries valid read data and output is enabled |

## Verification
The assertions check the timing that can be seen at the ports on every cycle. A read command must raise `dOutEn` one edge later in pipelined mode and at once in flow-through mode. A deselected or sleeping edge must leave `dOutEn` low at the matching point. A stalled edge must leave `dOut` unchanged. Data values can only be shown by the bench's scenarios, which compare every read against a reference memory that applies late writes at their data edge. Those scenarios cover full fills and readbacks, tight read/write alternation with same-address forwarding, partial byte writes, both burst orders from every start offset, chip-enable and sleep refusals, stalls inside bursts and write windows, and the asynchronous output enable.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/1ps
package zt_sram_pkg;
  // Strobes from the control to the datapath, valid for the access issued at the last enabled edge.
  typedef struct packed {
    logic rd;
    logic wr;
  } accStb_t;
endpackage

// File: rtl/zt_sram_ctrl.sv
`timescale 1ns/1ps
module zt_sram_ctrl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              orderSel,
  input  logic              sel1N,
  input  logic              sel2N,
  input  logic              sel3,
  input  logic              sleep,
  input  logic              advance,
  input  logic              weN,
  input  logic [NBYTES-1:0] byteWeN,
  input  logic [ADDR_W-1:0] addr,
  output accStb_t           acc,
  output logic [ADDR_W-1:0] accAddr,
  output logic [NBYTES-1:0] accMask
);
  localparam int CNT_W = 2;

  logic [ADDR_W-1:0] baseAddr, nextBase, effAddr;
  logic [CNT_W-1:0]  cnt, nextCnt, lowBits;
  logic              active, nextActive, isWrite, nextWrite, chipSel;

  assign chipSel = !sel1N && !sel2N && sel3;

  always_comb begin
    nextBase   = baseAddr;
    nextCnt    = cnt;
    nextWrite  = isWrite;
    nextActive = 1'b0;
    if (!sleep) begin
      if (advance) begin
        if (active) begin
          nextActive = 1'b1;
          nextCnt    = cnt + CNT_W'(1);
        end
      end else if (chipSel) begin
        nextActive = 1'b1;
        nextBase   = addr;
        nextCnt    = '0;
        nextWrite  = !weN;
      end
    end
  end

  assign lowBits = orderSel ? (nextBase[CNT_W-1:0] ^ nextCnt)
                            : (nextBase[CNT_W-1:0] + nextCnt);
  assign effAddr = {nextBase[ADDR_W-1:CNT_W], lowBits};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      cnt      <= '0;
      active   <= 1'b0;
      isWrite  <= 1'b0;
      acc      <= '0;
      accAddr  <= '0;
      accMask  <= '0;
    end else if (!ceN) begin
      baseAddr <= nextBase;
      cnt      <= nextCnt;
      active   <= nextActive;
      isWrite  <= nextWrite;
      acc.rd   <= nextActive && !nextWrite;
      acc.wr   <= nextActive && nextWrite;
      accAddr  <= effAddr;
      accMask  <= ~byteWeN;
    end
  end
endmodule

// File: rtl/zt_sram_dp.sv
`timescale 1ns/1ps
module zt_sram_dp
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ceN,
  input  logic                     pipeMode,
  input  logic                     oeN,
  input  accStb_t                  acc,
  input  logic [ADDR_W-1:0]        accAddr,
  input  logic [NBYTES-1:0]        accMask,
  input  logic [NBYTES*BYTE_W-1:0] dIn,
  output logic [NBYTES*BYTE_W-1:0] dOut,
  output logic                     dOutEn
);
  localparam int DATA_W = NBYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] arrayWord, readWord, outReg;
  logic              lateWr, outValid, fwdHit, commitEn;
  logic [ADDR_W-1:0] lateAddr, commitAddr;
  logic [NBYTES-1:0] lateMask, commitMask;

  // Second late-write stage is only consumed in pipelined mode.
  assign commitEn   = pipeMode ? lateWr   : acc.wr;
  assign commitAddr = pipeMode ? lateAddr : accAddr;
  assign commitMask = pipeMode ? lateMask : accMask;

  assign arrayWord = mem[accAddr];
  assign fwdHit    = pipeMode && lateWr && (lateAddr == accAddr);

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign readWord[b*BYTE_W +: BYTE_W] = (fwdHit && lateMask[b]) ? dIn[b*BYTE_W +: BYTE_W]
                                                                 : arrayWord[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!ceN && commitEn) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (commitMask[b]) mem[commitAddr][b*BYTE_W +: BYTE_W] <= dIn[b*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lateWr   <= 1'b0;
      lateAddr <= '0;
      lateMask <= '0;
      outReg   <= '0;
      outValid <= 1'b0;
    end else if (!ceN) begin
      lateWr   <= acc.wr;
      lateAddr <= accAddr;
      lateMask <= accMask;
      outValid <= acc.rd;
      if (acc.rd) outReg <= readWord;
    end
  end

  assign dOut   = pipeMode ? outReg : arrayWord;
  assign dOutEn = (pipeMode ? outValid : acc.rd) && !oeN;
endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     pipeMode,
  input  logic                     orderSel,
  input  logic                     ceN,
  input  logic                     sel1N,
  input  logic                     sel2N,
  input  logic                     sel3,
  input  logic                     sleep,
  input  logic                     advance,
  input  logic                     weN,
  input  logic [NBYTES-1:0]        byteWeN,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NBYTES*BYTE_W-1:0] dIn,
  input  logic                     oeN,
  output logic [NBYTES*BYTE_W-1:0] dOut,
  output logic                     dOutEn
);
  accStb_t           acc;
  logic [ADDR_W-1:0] accAddr;
  logic [NBYTES-1:0] accMask;

  zt_sram_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .orderSel(orderSel),
    .sel1N(sel1N), .sel2N(sel2N), .sel3(sel3), .sleep(sleep),
    .advance(advance), .weN(weN), .byteWeN(byteWeN), .addr(addr),
    .acc(acc), .accAddr(accAddr), .accMask(accMask)
  );

  zt_sram_dp #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .pipeMode(pipeMode), .oeN(oeN),
    .acc(acc), .accAddr(accAddr), .accMask(accMask), .dIn(dIn),
    .dOut(dOut), .dOutEn(dOutEn)
  );
endmodule

// File: rtl/zt_sram_chk.sv
`timescale 1ns/1ps
module zt_sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              pipeMode,
  input logic              ceN,
  input logic              sel1N,
  input logic              sel2N,
  input logic              sel3,
  input logic              sleep,
  input logic              advance,
  input logic              weN,
  input logic              oeN,
  input logic [DATA_W-1:0] dOut,
  input logic              dOutEn
);
  logic chipSel, issueRd, issueIdle;

  assign chipSel   = !sel1N && !sel2N && sel3;
  assign issueRd   = rstN && !ceN && !advance && chipSel && !sleep && weN;
  assign issueIdle = rstN && !ceN && (sleep || (!advance && !chipSel));

  AST_FLOW_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && $past(issueIdle)) |-> !dOutEn); // R1

  AST_PIPE_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && $past(issueIdle, 2) && $past(!ceN)) |-> !dOutEn); // R13

  AST_PIPE_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && $past(issueRd, 2) && $past(!ceN) && !oeN) |-> dOutEn); // R2

  AST_FLOW_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && $past(issueRd) && !oeN) |-> dOutEn); // R3

  AST_STALL_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> $stable(dOut)); // R10
endmodule

bind zt_sram zt_sram_chk #(.DATA_W(NBYTES*BYTE_W)) chk_i (
  .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .ceN(ceN),
  .sel1N(sel1N), .sel2N(sel2N), .sel3(sel3), .sleep(sleep),
  .advance(advance), .weN(weN), .oeN(oeN), .dOut(dOut), .dOutEn(dOutEn)
);

// File: tb/zt_sram_tb_top.sv
`timescale 1ns/1ps
module zt_sram_tb_top;
  localparam int ADDR_W = 6;
  localparam int NBYTES = 2;
  localparam int BYTE_W = 9;
  localparam int DATA_W = NBYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int RING   = 16;

  logic clk = 1'b0;
  logic rstN, pipeMode, orderSel, ceN, sel1N, sel2N, sel3, sleep, advance, weN, oeN;
  logic [NBYTES-1:0] byteWeN;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dIn, dOut;
  logic dOutEn;

  always #2 clk = ~clk;

  zt_sram #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) dut_i (
    .clk(clk), .rstN(rstN), .pipeMode(pipeMode), .orderSel(orderSel), .ceN(ceN),
    .sel1N(sel1N), .sel2N(sel2N), .sel3(sel3), .sleep(sleep), .advance(advance),
    .weN(weN), .byteWeN(byteWeN), .addr(addr), .dIn(dIn), .oeN(oeN),
    .dOut(dOut), .dOutEn(dOutEn)
  );

  int tests = 0;
  int fails = 0;
  int edgeNo = 0;

  // Reference model state
  logic [DATA_W-1:0] refMem [DEPTH];
  logic              mActive, mWrite;
  logic [ADDR_W-1:0] mBase;
  logic [1:0]        mCnt;
  logic              wPend [RING];
  logic [ADDR_W-1:0] wAddr [RING];
  logic [NBYTES-1:0] wMask [RING];
  logic [DATA_W-1:0] wData [RING];
  logic              rPend [RING];
  logic [ADDR_W-1:0] rAddr [RING];
  logic [DATA_W-1:0] prevOut;
  logic              prevEn;

  function automatic logic [DATA_W-1:0] pat(input int e);
    return DATA_W'((e * 613 + 91) ^ (e << 7));
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (edge %0d)", tag, act, exp, edgeNo);
    end
  endtask

  // One enabled clock: starts just after a falling edge, ends on the next falling edge.
  task automatic cyc(input logic aAdv, input logic aWeN, input logic aS1, input logic aS2,
                     input logic aS3, input logic aSleep, input logic aOeN,
                     input logic [ADDR_W-1:0] aAddr, input logic [NBYTES-1:0] aBe,
                     input string tag);
    int nx, s, lat;
    logic act, rv;
    logic [1:0] low;
    logic [ADDR_W-1:0] ea, ra;
    nx = edgeNo + 1;
    lat = pipeMode ? 2 : 1;
    ceN = 1'b0; advance = aAdv; weN = aWeN; sel1N = aS1; sel2N = aS2; sel3 = aS3;
    sleep = aSleep; oeN = aOeN; addr = aAddr; byteWeN = aBe;
    dIn = wPend[nx % RING] ? wData[nx % RING] : (pat(nx) ^ DATA_W'(18'h15555));
    act = 1'b0;
    if (!aSleep) begin
      if (aAdv) begin
        if (mActive) begin act = 1'b1; mCnt = mCnt + 2'd1; end
      end else if (!aS1 && !aS2 && aS3) begin
        act = 1'b1; mBase = aAddr; mCnt = 2'd0; mWrite = !aWeN;
      end
    end
    mActive = act;
    low = orderSel ? (mBase[1:0] ^ mCnt) : (mBase[1:0] + mCnt);
    ea = {mBase[ADDR_W-1:2], low};
    if (act && mWrite) begin
      s = (nx + lat) % RING;
      wPend[s] = 1'b1; wAddr[s] = ea; wMask[s] = ~aBe; wData[s] = pat(nx + lat);
    end
    if (act && !mWrite) begin
      s = (nx + (pipeMode ? 1 : 0)) % RING;
      rPend[s] = 1'b1; rAddr[s] = ea;
    end
    @(posedge clk);
    edgeNo = nx;
    s = nx % RING;
    if (wPend[s]) begin
      for (int b = 0; b < NBYTES; b++)
        if (wMask[s][b]) refMem[wAddr[s]][b*BYTE_W +: BYTE_W] = wData[s][b*BYTE_W +: BYTE_W];
      wPend[s] = 1'b0;
    end
    rv = rPend[s]; ra = rAddr[s]; rPend[s] = 1'b0;
    @(negedge clk);
    check(tag, 32'(dOutEn), 32'(rv && !aOeN));
    if (rv) check(tag, 32'(dOut), 32'(refMem[ra]));
    prevOut = dOut; prevEn = dOutEn;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, '0, tag);
  endtask
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [NBYTES-1:0] be, input string tag);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, be, tag);
  endtask
  task automatic adv(input logic [NBYTES-1:0] be, input string tag);
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, be, tag);
  endtask
  task automatic idle(input string tag);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, '0, tag);
  endtask

  // R10: a disabled edge with a live-looking read command and wrong data must change nothing.
  task automatic stall();
    ceN = 1'b1; advance = 1'b0; weN = 1'b1; sel1N = 1'b0; sel2N = 1'b0; sel3 = 1'b1;
    addr = '0; byteWeN = '0; dIn = ~dIn;
    @(posedge clk);
    @(negedge clk);
    check("R10 stall dOut", 32'(dOut), 32'(prevOut));
    check("R10 stall dOutEn", 32'(dOutEn), 32'(prevEn));
  endtask

  task automatic doReset(input logic pm);
    @(negedge clk);
    rstN = 1'b0; pipeMode = pm; ceN = 1'b0; sel1N = 1'b1; sel2N = 1'b1; sel3 = 1'b0;
    advance = 1'b0; weN = 1'b1; sleep = 1'b0; oeN = 1'b0; addr = '0; byteWeN = '0; dIn = '0;
    mActive = 1'b0; mWrite = 1'b0; mBase = '0; mCnt = '0;
    for (int i = 0; i < RING; i++) begin wPend[i] = 1'b0; rPend[i] = 1'b0; end
    repeat (2) @(negedge clk);
    check("R1 reset dOutEn", 32'(dOutEn), 32'd0);
    rstN = 1'b1;
  endtask

  task automatic runMode(input logic pm);
    string tw, tr;
    tw = pm ? "R4 write fill" : "R5 write fill";
    tr = pm ? "R2 read sweep" : "R3 read sweep";
    orderSel = 1'b0;
    doReset(pm);
    for (int a = 0; a < DEPTH; a++) wr(ADDR_W'(a), '0, tw);
    idle(tw); idle(tw);
    for (int a = 0; a < DEPTH; a++) rd(ADDR_W'(a), tr);
    idle(tr); idle(tr);
    // R6 / R11: tight alternation, reads right behind writes to the same word
    for (int i = 0; i < 16; i++) begin
      wr(ADDR_W'(i * 5 + 1), '0, "R6 alt write");
      rd(ADDR_W'(i * 5 + 1), "R11 read after write");
      rd(ADDR_W'(i * 3), "R6 alt read");
    end
    idle("R6"); idle("R6");
    // R9: partial byte writes
    wr(6'd20, 2'b01, "R9 upper byte only");
    rd(6'd20, "R9 merged read");
    wr(6'd20, 2'b10, "R9 lower byte only");
    rd(6'd20, "R9 merged read");
    wr(6'd21, 2'b11, "R9 no bytes");
    idle("R9"); rd(6'd21, "R9 untouched word"); idle("R9"); idle("R9");
    // R7 / R8: bursts from every start offset, both orders, with counter wrap
    for (int o = 0; o < 2; o++) begin
      orderSel = o[0];
      for (int st = 0; st < 4; st++) begin
        wr(ADDR_W'(32 + st), '0, o ? "R8 burst write" : "R7 burst write");
        for (int k = 0; k < 3; k++) adv(NBYTES'(k == 1 ? 1 : 0), o ? "R8 burst write" : "R7 burst write");
        rd(ADDR_W'(32 + st), o ? "R8 burst read" : "R7 burst read");
        for (int k = 0; k < 5; k++) adv('0, o ? "R8 burst read" : "R7 burst read");
        idle("R7/8 gap");
      end
      idle("R7 gap"); idle("R8 gap");
    end
    orderSel = 1'b0;
    // R1: each chip-enable fault refuses the write and the read
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 6'd5, '0, "R1 sel1N high");
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'd5, '0, "R1 sel2N high");
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd5, '0, "R1 sel3 low");
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 6'd5, '0, "R1 deselected read");
    idle("R1"); idle("R1"); rd(6'd5, "R1 word unchanged"); idle("R1"); idle("R1");
    // R13: sleep refuses accesses and stops bursts
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'd9, '0, "R13 sleep write");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'd9, '0, "R13 sleep read");
    rd(6'd7, "R13 burst start");
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, '0, "R13 sleep on advance");
    adv('0, "R13 advance after sleep");
    idle("R13"); rd(6'd9, "R13 word unchanged"); idle("R13"); idle("R13");
    // R10: stalls inside a read burst and inside a write data window
    rd(6'd40, "R10 burst"); stall(); adv('0, "R10 burst"); stall(); stall();
    adv('0, "R10 burst"); idle("R10"); stall(); idle("R10");
    wr(6'd11, '0, "R10 write"); stall(); stall(); idle("R10"); idle("R10");
    rd(6'd11, "R10 delayed write data"); idle("R10"); idle("R10");
    // R12: output enable, synchronous view and asynchronous gating
    rd(6'd12, "R12 read");
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '0, '0, "R12 oeN high");
    idle("R12"); idle("R12");
    rd(6'd13, "R12 read");
    if (pm) idle("R12");
    check("R12 visible before oeN", 32'(dOutEn), 32'd1);
    oeN = 1'b1; #1;
    check("R12 async gating", 32'(dOutEn), 32'd0);
    oeN = 1'b0;
    idle("R12"); idle("R12");
  endtask

  initial begin
    rstN = 1'b0; pipeMode = 1'b1; orderSel = 1'b0; ceN = 1'b0; sel1N = 1'b1; sel2N = 1'b1;
    sel3 = 1'b0; sleep = 1'b0; advance = 1'b0; weN = 1'b1; oeN = 1'b0; byteWeN = '0;
    addr = '0; dIn = '0; prevOut = '0; prevEn = 1'b0;
    runMode(1'b1);
    runMode(1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule